// File: doc/BRIEF.md
# Single-Bit Page ECC Corrector

This block acts on the verdict of a whole-page Hamming-style parity checker once a page has been read into a local word buffer. A one-cycle `start` pulse captures a three-flag status word and a 16-bit parity word. The block sorts the outcome into one of three results: clean, corrected or uncorrectable. When one data bit is at fault, it fixes that bit in place with a read-modify-write on the buffer's synchronous port.

The block accepts buffers of 8-bit and 16-bit data words. A two-bit selector chooses the data area of the page: 512, 1024, 2048 or 4096 bytes, which with the spare area gives 528, 1056, 2112 or 4224 bytes. Outside any correction, the block packs the parity word and the inverse-parity word into the four-byte code that is stored in the spare area.

Top module: `page_ecc_fixer`

## Requirements
- R1: After reset, `result` is 00 (clean), `fix_count`, `done` and `busy` are 0, and the buffer is neither read nor written while the block is idle.
- R2: Status bits are: bit 0 error present, bit 1 multiple errors, bit 2 error inside the stored code. When bit 0 is clear, the result is clean with no buffer access, and `done` pulses one cycle after `start`.
- R3: When bits 0 and 1 are both set, the result is clean if the parity word is 16'hFFFF, which marks an erased page. For any other parity value it is 10 (uncorrectable). This check takes priority over bit 2, and no buffer write occurs.
- R4: When bit 0 is set, bit 1 is clear and bit 2 is set, the fault lies in the stored code. The result is clean and the buffer is left untouched.
- R5: Otherwise the block reads the buffer word at parity[15:4] and writes it back with bit parity[3:0] inverted. The read, the capture and the write take one cycle each. `done` pulses in the cycle after the write, with `result` 01 (corrected).
- R6: When `bus16` is 0, data words are 8 bits. A bit offset above 7 gives an uncorrectable result with no access, and the upper buffer byte is written back unchanged.
- R7: The number of valid data words is (512 << `size_sel`) in 8-bit mode and (256 << `size_sel`) in 16-bit mode. A word address at or above this limit gives an uncorrectable result with no access.
- R8: `ecc_code` holds four bytes, from bits [7:0] upward: parity[7:0], parity[15:8], inv_parity[7:0], inv_parity[15:8].
- R9: A `start` that arrives while `busy` is high is ignored. The status and parity used by a correction are the values captured at its own `start`.
- R10: With each `done`, `err_word` and `err_bit` give the captured word address and bit offset. `fix_count` is 1 only when the result is corrected, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to evaluate the status and parity words |
| bus16 | input | 1 | 1: 16-bit data words, 0: 8-bit data words |
| size_sel | input | 2 | Data area 512 << size_sel bytes |
| status | input | 3 | {code error, multiple errors, error present} |
| parity | input | 16 | Word address [15:4], bit offset [3:0] |
| inv_parity | input | 16 | Inverse-parity word |
| ecc_code | output | 32 | Packed four-byte code |
| busy | output | 1 | Correction in progress |
| done | output | 1 | One-cycle pulse when the result is valid |
| result | output | 2 | 00 clean, 01 corrected, 10 uncorrectable |
| fix_count | output | 1 | Number of bits corrected |
| err_word | output | 12 | Captured word address |
| err_bit | output | 4 | Captured bit offset |
| mem_rd | output | 1 | Buffer read strobe |
| mem_wr | output | 1 | Buffer write strobe |
| mem_addr | output | 12 | Buffer word address |
| mem_wdata | output | 16 | Buffer write data |
| mem_rdata | input | 16 | Buffer read data, valid the cycle after `mem_rd` |

## Verification
A new `start` can arrive in the same cycle as the read-modify-write of an earlier correction. It can also arrive together with new parity values, which the combinational code packing must show at once. The bench raises `start` with a different address one cycle into a correction, and changes the parity inputs while the correction is still running. It then checks three things: only the first word was flipped, exactly one write took place, and `done` came at the correction's own latency. It also checks that `ecc_code` followed the new inputs during that time.

// File: rtl/page_ecc_fixer.sv
module page_ecc_fixer #(
  parameter int ADDR_W = 12,
  parameter int BIT_W  = 4,
  parameter int DATA_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                bus16,
  input  logic [1:0]          size_sel,
  input  logic [2:0]          status,
  input  logic [15:0]         parity,
  input  logic [15:0]         inv_parity,
  output logic [31:0]         ecc_code,
  output logic                busy,
  output logic                done,
  output logic [1:0]          result,
  output logic                fix_count,
  output logic [ADDR_W-1:0]   err_word,
  output logic [BIT_W-1:0]    err_bit,
  output logic                mem_rd,
  output logic                mem_wr,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [DATA_W-1:0]   mem_wdata,
  input  logic [DATA_W-1:0]   mem_rdata
);
  localparam int LIM_W = ADDR_W + 2;
  localparam logic [1:0] RES_CLEAN = 2'b00;
  localparam logic [1:0] RES_FIXED = 2'b01;
  localparam logic [1:0] RES_BAD   = 2'b10;

  typedef enum logic [1:0] {S_IDLE, S_RD, S_CAP, S_WR} st_t;
  st_t state;

  logic [DATA_W-1:0] hold_q;
  logic [LIM_W-1:0]  word_lim;
  logic              addr_ok, bit_ok, erased, need_fix;
  logic [1:0]        verdict;

  assign ecc_code = {inv_parity, parity};

  assign word_lim = bus16 ? (LIM_W'(256) << size_sel) : (LIM_W'(512) << size_sel);
  assign addr_ok  = LIM_W'(parity[15:4]) < word_lim;
  assign bit_ok   = bus16 | ~parity[3];
  assign erased   = &parity;

  always_comb begin
    need_fix = 1'b0;
    if (!status[0])                verdict = RES_CLEAN;
    else if (status[1])            verdict = erased ? RES_CLEAN : RES_BAD;
    else if (status[2])            verdict = RES_CLEAN;
    else if (!addr_ok || !bit_ok)  verdict = RES_BAD;
    else begin
      verdict  = RES_FIXED;
      need_fix = 1'b1;
    end
  end

  assign busy      = state != S_IDLE;
  assign mem_rd    = state == S_RD;
  assign mem_wr    = state == S_WR;
  assign mem_addr  = err_word;
  assign mem_wdata = hold_q ^ (DATA_W'(1) << err_bit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      done      <= 1'b0;
      result    <= RES_CLEAN;
      fix_count <= 1'b0;
      err_word  <= '0;
      err_bit   <= '0;
      hold_q    <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          err_word  <= parity[15:4];
          err_bit   <= parity[3:0];
          fix_count <= 1'b0;
          if (need_fix) state <= S_RD;
          else begin
            result <= verdict;
            done   <= 1'b1;
          end
        end
        S_RD:  state <= S_CAP;
        S_CAP: begin
          hold_q <= mem_rdata;
          state  <= S_WR;
        end
        S_WR: begin
          state     <= S_IDLE;
          result    <= RES_FIXED;
          fix_count <= 1'b1;
          done      <= 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

module page_ecc_fixer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic [1:0]  result,
  input logic        fix_count,
  input logic        mem_rd,
  input logic        mem_wr,
  input logic [11:0] mem_addr
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_rd && !mem_wr));
  // R5
  rd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> (busy && !mem_rd && !mem_wr));
  // R5
  wr_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> ($past(mem_rd, 2) && mem_addr == $past(mem_addr, 2)));
  // R5
  fixed_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && result == 2'b01) |-> $past(mem_wr));
  // R3
  other_no_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && result != 2'b01) |-> !$past(mem_wr));
  // R10
  count_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (fix_count == (result == 2'b01)));
  // R9
  single_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind page_ecc_fixer page_ecc_fixer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .result(result),
  .fix_count(fix_count), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr)
);

// File: tb/sim_page_ecc_fixer.sv
`timescale 1ns/1ps
module sim_page_ecc_fixer;
  logic clk = 0, rst_n = 0, start = 0, bus16 = 0;
  logic [1:0] size_sel = 0;
  logic [2:0] status = 0;
  logic [15:0] parity = 0, inv_parity = 0;
  logic [31:0] ecc_code;
  logic busy, done, fix_count, mem_rd, mem_wr;
  logic [1:0] result;
  logic [11:0] err_word, err_bit_w, mem_addr;
  logic [3:0] err_bit;
  logic [15:0] mem_wdata, mem_rdata;
  logic [15:0] mem [4096];
  int checks = 0, fails = 0, wr_cnt = 0, lat = 0;

  always #2 clk = ~clk;

  page_ecc_fixer u0 (.clk(clk), .rst_n(rst_n), .start(start), .bus16(bus16),
    .size_sel(size_sel), .status(status), .parity(parity), .inv_parity(inv_parity),
    .ecc_code(ecc_code), .busy(busy), .done(done), .result(result),
    .fix_count(fix_count), .err_word(err_word), .err_bit(err_bit),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

  assign err_bit_w = {8'd0, err_bit};

  always @(posedge clk) begin
    if (mem_wr) begin mem[mem_addr] <= mem_wdata; wr_cnt <= wr_cnt + 1; end
    if (mem_rd) mem_rdata <= mem[mem_addr];
  end

  function automatic logic [15:0] pat(int a);
    return 16'(a * 40503) ^ 16'h5A5A;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run(logic b16, logic [1:0] sel, logic [2:0] st, logic [15:0] par);
    @(negedge clk);
    bus16 = b16; size_sel = sel; status = st; parity = par; start = 1;
    wr_cnt = 0; lat = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      start = 0; lat++;
      if (done) break;
    end
  endtask

  task automatic t_reset;
    chk("R1 result", result, 0); chk("R1 done", done, 0);
    chk("R1 busy", busy, 0); chk("R1 count", fix_count, 0);
    chk("R1 rd/wr", {mem_rd, mem_wr}, 0);
  endtask

  task automatic t_clean;
    run(1, 2, 3'b110, 16'h0123);
    chk("R2 result", result, 0); chk("R2 latency", lat, 1); chk("R2 writes", wr_cnt, 0);
    chk("R10 count clean", fix_count, 0);
  endtask

  task automatic t_erased;
    run(0, 3, 3'b011, 16'hFFFF);
    chk("R3 erased result", result, 0); chk("R3 erased writes", wr_cnt, 0);
    run(0, 3, 3'b011, 16'h1234);
    chk("R3 multi result", result, 2);
    run(1, 3, 3'b111, 16'h0040);
    chk("R3 priority result", result, 2); chk("R3 priority writes", wr_cnt, 0);
  endtask

  task automatic t_code_err;
    run(1, 1, 3'b101, {12'd20, 4'd3});
    chk("R4 result", result, 0); chk("R4 writes", wr_cnt, 0);
    chk("R4 buffer", mem[20], pat(20));
  endtask

  task automatic t_fix16;
    run(1, 2, 3'b001, {12'd700, 4'd13});
    chk("R5 result", result, 1); chk("R5 latency", lat, 4); chk("R5 writes", wr_cnt, 1);
    chk("R5 buffer", mem[700], pat(700) ^ 16'h2000);
    chk("R10 word", err_word, 700); chk("R10 bit", err_bit_w, 13); chk("R10 count", fix_count, 1);
    run(1, 2, 3'b001, {12'd700, 4'd13});
    chk("R5 restore", mem[700], pat(700));
  endtask

  task automatic t_fix8;
    run(0, 0, 3'b001, {12'd511, 4'd7});
    chk("R6 result", result, 1); chk("R6 buffer", mem[511], pat(511) ^ 16'h0080);
    run(0, 0, 3'b001, {12'd3, 4'd9});
    chk("R6 offset result", result, 2); chk("R6 offset writes", wr_cnt, 0);
    chk("R6 offset buffer", mem[3], pat(3));
  endtask

  task automatic t_limit;
    run(1, 0, 3'b001, {12'd256, 4'd0});
    chk("R7 over result", result, 2); chk("R7 over writes", wr_cnt, 0);
    run(1, 0, 3'b001, {12'd255, 4'd15});
    chk("R7 edge result", result, 1); chk("R7 edge buffer", mem[255], pat(255) ^ 16'h8000);
    run(0, 3, 3'b001, {12'd4095, 4'd0});
    chk("R7 max result", result, 1); chk("R7 max buffer", mem[4095], pat(4095) ^ 16'h0001);
    run(0, 1, 3'b001, {12'd1024, 4'd1});
    chk("R7 8bit over", result, 2);
  endtask

  task automatic t_pack;
    @(negedge clk);
    parity = 16'hA1B2; inv_parity = 16'hC3D4;
    #1 chk("R8 pack", ecc_code, 32'hC3D4A1B2);
  endtask

  task automatic t_overlap;
    @(negedge clk);
    bus16 = 1; size_sel = 3; status = 3'b001; parity = {12'd40, 4'd2}; start = 1;
    wr_cnt = 0; lat = 0;
    @(negedge clk); lat++;
    parity = {12'd41, 4'd5}; inv_parity = 16'h0F0F; start = 1;
    #1 chk("R9 pack during busy", ecc_code, {16'h0F0F, 12'd41, 4'd5});
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      start = 0; lat++;
      if (done) break;
    end
    chk("R9 latency", lat, 4); chk("R9 writes", wr_cnt, 1);
    chk("R9 first word", mem[40], pat(40) ^ 16'h0004);
    chk("R9 second word", mem[41], pat(41));
    chk("R9 word", err_word, 40);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = pat(i);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_clean(); t_erased(); t_code_err(); t_fix16(); t_fix8();
    t_limit(); t_pack(); t_overlap();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule